// File: doc/BRIEF.md
# Serial Transmitter with Per-Bit Fine Rate Trim

This block turns one parallel character into an asynchronous serial frame on a single line that idles high. The frame is a low start bit, then five to eight data bits sent least-significant first, then an optional parity bit, then one or two high stop bits. A frame has at most 12 bit positions.

Timing comes from a programmable divisor. One sub-tick lasts `div_i + 1` clock cycles, and a plain bit lasts 16 sub-ticks. An integer divisor alone leaves a residual rate error that grows along the frame. A 24-bit trim word removes most of it by giving each bit position its own two-bit code. The code can lengthen that bit to 17 sub-ticks or shorten it to 15, so the frame length can be tuned in steps of 1/16 of a bit.

A character is handed over with a valid/ready handshake. The divisor, frame format and trim word are captured together with the character, so a frame already on the line is never disturbed by a change to them.

Top module: `uart_fine_tx`

## Requirements
- R1: While reset is asserted and after it is released, `txd_o` is 1, `busy_o` is 0 and `tx_ready_o` is 1.
- R2: A character is accepted on a rising clock edge where `tx_valid_i` and `tx_ready_o` are both 1. From the next cycle `busy_o` is 1, `tx_ready_o` is 0 and `txd_o` carries the low start bit.
- R3: A bit whose trim code is 0 lasts exactly 16*(`div_i`+1) clock cycles, with `div_i` taken at acceptance.
- R4: Bit position i counts in order of transmission, with the start bit at position 0. Its trim code sits at `jitter_i[2i+1:2i]`. Code 1 makes the bit 17*(`div_i`+1) cycles long, code 3 makes it 15*(`div_i`+1) cycles long, and code 2 behaves like code 0.
- R5: `line_cfg_i[1:0]` = 0, 1, 2 or 3 sends 5, 6, 7 or 8 data bits, least-significant first, and the unused upper data bits are ignored.
- R6: `line_cfg_i[5:3]` selects the parity bit that follows the data bits: 4 makes the count of ones over data and parity odd, 5 makes it even, 6 sends a constant 1 and 7 sends a constant 0. Values 0 to 3 send no parity bit.
- R7: `line_cfg_i[2]` = 0 sends one high stop bit and 1 sends two.
- R8: Data, `line_cfg_i`, `jitter_i` and `div_i` are sampled only at acceptance. Changing them while a frame is in progress does not alter that frame.
- R9: In the cycle after the last stop bit ends, `busy_o` returns to 0, `tx_ready_o` returns to 1 and the line stays high. While busy, `tx_valid_i` is ignored, so every frame is followed by at least one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that drives the bit timing |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | DIV_W | Sub-tick divisor; one sub-tick is div_i+1 cycles |
| line_cfg_i | input | 6 | [1:0] data length code, [2] stop count, [5:3] parity mode |
| jitter_i | input | 24 | Two-bit trim code per bit position |
| tx_data_i | input | 8 | Character to send |
| tx_valid_i | input | 1 | Character present |
| tx_ready_o | output | 1 | Block can accept a character |
| txd_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench builds the block with `DIV_W` = 4. This keeps divisor values small, so frames stay short enough for every cycle of every frame to be compared against a behavioural waveform. It also makes a divisor of 0 reachable, where one sub-tick is a single cycle and a 15-, 16- or 17-cycle bit is directly visible. The frames mix all four trim codes, every data length, every parity mode and both stop counts. Back-to-back frames are sent with the format changed in mid-frame.

// File: rtl/uft_pkg.sv
package uft_pkg;
  localparam int FRAME_MAX = 12;
  localparam int JIT_W     = 2 * FRAME_MAX;
  localparam int DATA_MAX  = 8;
  localparam int SUB_NOM   = 16;
  localparam int POS_W     = $clog2(FRAME_MAX + 1);
  localparam int SUB_W     = $clog2(SUB_NOM + 2);
  localparam int CFG_W     = 6;

  typedef enum logic [1:0] {
    TRIM_KEEP   = 2'd0,
    TRIM_WIDEN  = 2'd1,
    TRIM_IDLE   = 2'd2,
    TRIM_NARROW = 2'd3
  } trim_code_e;

  // Number of sub-ticks a bit lasts for a given trim code
  function automatic logic [SUB_W-1:0] sub_count(input logic [1:0] code);
    case (trim_code_e'(code))
      TRIM_WIDEN:  sub_count = SUB_W'(SUB_NOM + 1);
      TRIM_NARROW: sub_count = SUB_W'(SUB_NOM - 1);
      default:     sub_count = SUB_W'(SUB_NOM);
    endcase
  endfunction
endpackage

// File: rtl/uft_frame_fmt.sv
module uft_frame_fmt
  import uft_pkg::*;
(
  input  logic [DATA_MAX-1:0]  data_i,
  input  logic [CFG_W-1:0]     cfg_i,
  output logic [FRAME_MAX-1:0] bits_o,
  output logic [POS_W-1:0]     len_o
);
  int                  nd;
  logic                par_en;
  logic                par_bit;
  logic [DATA_MAX-1:0] dmask;

  always_comb begin
    nd     = 5 + int'(cfg_i[1:0]);
    par_en = cfg_i[5];
    dmask  = '0;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < nd) dmask[i] = data_i[i];
    end
    case (cfg_i[4:3])
      2'd0:    par_bit = ~^dmask;
      2'd1:    par_bit = ^dmask;
      2'd2:    par_bit = 1'b1;
      default: par_bit = 1'b0;
    endcase
    bits_o    = '1;
    bits_o[0] = 1'b0;
    for (int i = 0; i <= DATA_MAX; i++) begin
      if (i < nd) bits_o[1 + i] = data_i[i];
      else if (par_en && i == nd) bits_o[1 + i] = par_bit;
    end
    len_o = POS_W'(2 + nd + int'(par_en) + int'(cfg_i[2]));
  end
endmodule

// File: rtl/uft_prescale.sv
module uft_prescale #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q == div_i);

  always_ff @(posedge clk) begin
    if (rst || clear_i) cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/uart_fine_tx.sv
module uart_fine_tx
  import uft_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DIV_W-1:0]     div_i,
  input  logic [CFG_W-1:0]     line_cfg_i,
  input  logic [JIT_W-1:0]     jitter_i,
  input  logic [DATA_MAX-1:0]  tx_data_i,
  input  logic                 tx_valid_i,
  output logic                 tx_ready_o,
  output logic                 txd_o,
  output logic                 busy_o
);
  logic [FRAME_MAX-1:0] fmt_bits;
  logic [POS_W-1:0]     fmt_len;
  logic [FRAME_MAX-1:0] rest_q;
  logic [JIT_W-1:0]     trim_q;
  logic [DIV_W-1:0]     div_q;
  logic [POS_W-1:0]     left_q;
  logic [SUB_W-1:0]     sub_q;
  logic                 busy_q, ready_q, txd_q;
  logic                 pre_tick, accept, bit_end;

  uft_frame_fmt u_fmt (
    .data_i (tx_data_i),
    .cfg_i  (line_cfg_i),
    .bits_o (fmt_bits),
    .len_o  (fmt_len)
  );

  uft_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .clear_i (accept),
    .div_i   (div_q),
    .tick_o  (pre_tick)
  );

  assign accept  = tx_valid_i & ready_q;
  assign bit_end = busy_q & pre_tick & (sub_q == sub_count(trim_q[1:0]) - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      ready_q <= 1'b1;
      txd_q   <= 1'b1;
      rest_q  <= '1;
      trim_q  <= '0;
      div_q   <= '0;
      left_q  <= '0;
      sub_q   <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      ready_q <= 1'b0;
      txd_q   <= fmt_bits[0];
      rest_q  <= {1'b1, fmt_bits[FRAME_MAX-1:1]};
      trim_q  <= jitter_i;
      div_q   <= div_i;
      left_q  <= fmt_len;
      sub_q   <= '0;
    end else if (bit_end) begin
      sub_q <= '0;
      if (left_q == POS_W'(1)) begin
        busy_q  <= 1'b0;
        ready_q <= 1'b1;
        txd_q   <= 1'b1;
      end else begin
        txd_q  <= rest_q[0];
        rest_q <= {1'b1, rest_q[FRAME_MAX-1:1]};
        trim_q <= {2'b00, trim_q[JIT_W-1:2]};
        left_q <= left_q - 1'b1;
      end
    end else if (busy_q && pre_tick) begin
      sub_q <= sub_q + 1'b1;
    end
  end

  assign tx_ready_o = ready_q;
  assign txd_o      = txd_q;
  assign busy_o     = busy_q;
endmodule

// File: rtl/uart_fine_tx_chk.sv
module uart_fine_tx_chk (
  input logic clk,
  input logic rst,
  input logic tx_valid_i,
  input logic tx_ready_o,
  input logic txd_o,
  input logic busy_o
);
  p_idle_high_r9: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> txd_o);

  p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> !txd_o);

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_i && tx_ready_o) |=> (busy_o && !tx_ready_o));

  p_stop_before_idle_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> $past(txd_o));

  p_ready_after_frame_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> tx_ready_o);

  p_busy_ignores_valid_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !$fell(busy_o) && $past(busy_o)) |-> !tx_ready_o);
endmodule

bind uart_fine_tx uart_fine_tx_chk u_chk (.*);

// File: tb/uart_fine_tx_tb.sv
module uart_fine_tx_tb;
  localparam int DIV_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [DIV_W-1:0] div_i = '0;
  logic [5:0]       line_cfg_i = '0;
  logic [23:0]      jitter_i = '0;
  logic [7:0]       tx_data_i = '0;
  logic             tx_valid_i = 1'b0;
  logic             tx_ready_o, txd_o, busy_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit exp_q[$];
  bit exp_ready = 1'b1;
  string tag = "R1";

  always #10 clk = ~clk;

  uart_fine_tx #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst(rst), .div_i(div_i), .line_cfg_i(line_cfg_i),
    .jitter_i(jitter_i), .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i),
    .tx_ready_o(tx_ready_o), .txd_o(txd_o), .busy_o(busy_o)
  );

  task automatic chk(input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual %0b expected %0b at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  // Behavioural waveform of one frame, pushed one entry per clock cycle
  task automatic push_frame(input logic [7:0] d, input logic [5:0] cfg,
                            input logic [23:0] jit, input int dv);
    bit fr[$];
    int nd = 5 + int'(cfg[1:0]);
    int ones = 0;
    fr.push_back(1'b0);
    for (int i = 0; i < nd; i++) begin
      fr.push_back(d[i]);
      ones += int'(d[i]);
    end
    case (cfg[5:3])
      3'd4: fr.push_back((ones % 2) == 0);
      3'd5: fr.push_back((ones % 2) == 1);
      3'd6: fr.push_back(1'b1);
      3'd7: fr.push_back(1'b0);
      default: ;
    endcase
    fr.push_back(1'b1);
    if (cfg[2]) fr.push_back(1'b1);
    for (int p = 0; p < fr.size(); p++) begin
      int code = int'(jit[2*p +: 2]);
      int subs = (code == 1) ? 17 : (code == 3) ? 15 : 16;
      for (int c = 0; c < subs * (dv + 1); c++) exp_q.push_back(fr[p]);
    end
  endtask

  task automatic tick();
    bit exp_txd;
    bit exp_busy;
    if (tx_valid_i && exp_ready) push_frame(tx_data_i, line_cfg_i, jitter_i, int'(div_i));
    @(posedge clk);
    @(negedge clk);
    cycles++;
    if (exp_q.size() > 0) begin
      exp_txd  = exp_q.pop_front();
      exp_busy = 1'b1;
    end else begin
      exp_txd  = 1'b1;
      exp_busy = 1'b0;
    end
    exp_ready = !exp_busy;
    chk("txd", txd_o, exp_txd);
    chk("busy", busy_o, exp_busy);
    chk("ready", tx_ready_o, exp_ready);
  endtask

  task automatic send(input logic [7:0] d, input logic [5:0] cfg,
                      input logic [23:0] jit, input int dv);
    bit acc;
    tx_data_i  = d;
    line_cfg_i = cfg;
    jitter_i   = jit;
    div_i      = DIV_W'(dv);
    tx_valid_i = 1'b1;
    do begin
      acc = exp_ready;
      tick();
    end while (!acc);
    tx_valid_i = 1'b0;
    // R8: scramble the sampled inputs while the frame is in flight
    tx_data_i  = ~d;
    line_cfg_i = ~cfg;
    jitter_i   = ~jit;
    div_i      = DIV_W'(dv + 3);
  endtask

  task automatic drain();
    while (exp_q.size() > 0) tick();
    tick();
    tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("txd", txd_o, 1'b1);
    chk("busy", busy_o, 1'b0);
    chk("ready", tx_ready_o, 1'b1);
    rst = 1'b0;
    tick();
    tick();
    tag = "R2 R3 R5 R7";
    send(8'hA5, 6'b000_0_11, 24'h0, 0);
    drain();
    tag = "R4 R6 R7";
    send(8'h3B, 6'b100_1_00, 24'h9C6D31, 1);
    drain();
    tag = "R4 R5 R6";
    send(8'h5C, 6'b101_0_10, 24'hFFFFFF, 0);
    drain();
    tag = "R4 R6";
    send(8'h96, 6'b110_0_01, 24'h555555, 2);
    drain();
    tag = "R4 R6 R7";
    send(8'hFF, 6'b111_1_11, 24'hAAAAAA, 0);
    drain();
    tag = "R5 R6";
    send(8'hE1, 6'b010_0_11, 24'h0000C4, 1);
    drain();
    tag = "R8 R9";
    send(8'h42, 6'b100_0_11, 24'h00F00D, 0);
    send(8'h81, 6'b101_1_01, 24'h3300CC, 1);
    send(8'h7E, 6'b000_0_00, 24'h000001, 0);
    drain();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired, actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule